// File: doc/BRIEF.md
# DMA Channel Microcode Executor

This block is one DMA channel thread that runs a small byte-coded program. After a start pulse it fetches the program one byte at a time from a byte-wide memory with one cycle of read latency. Each instruction is one, two or six bytes long, and the first byte gives the length. The instructions set the source address, destination address and control flags, run up to two nested hardware loops, move words between memory and a one-word holding register, wait for posted writes to finish, and signal numbered events.

Loads and stores use a one-word data port. A request stays asserted until `dp_ready` is seen high. A store counts as outstanding from the cycle it is accepted until a one-cycle `dp_wack` returns for it. The write barrier and the end instruction both wait until no stores are outstanding. The channel shows its program counter and a 4-bit status code. An undefined opcode parks the channel in a sticky fault state and sets a fault flag.

Top module: `dmach_exec`

## Requirements
- R1: After synchronous reset the status is 0 (stopped), the program counter is 0, `undef_fault` is 0, and no fetch or data request is issued.
- R2: In the stopped state a `start` pulse loads `pc` from `start_pc` and sets status to 1 (executing). A `start` pulse in any other state has no effect on `pc` or on the status.
- R3: The first byte is the opcode, and it sets the instruction length: 0xBC is 6 bytes; 0x20, 0x22, 0x38, 0x3C and 0x34 are 2 bytes; all others are 1 byte. After each instruction `pc` advances by its length, except where a loop jumps back.
- R4: Opcode 0xBC loads a register from the little-endian 32-bit value in bytes 2..5. Byte 1 picks the register: 0 is the source address, 1 is the control word, 2 is the destination address. Any other byte-1 value is an undefined instruction.
- R5: Loop start is 0x20 (counter 0) or 0x22 (counter 1), and byte 1 is the iteration count minus one. Loop end is 0x38 (counter 0) or 0x3C (counter 1). At loop end, a nonzero counter is decremented and `pc` becomes the loop-end address minus byte 1. A zero counter falls through. The two counters are independent, so loops nest.
- R6: Load (0x04) reads the word at the source address into the holding register. Store (0x08) writes the holding register to the destination address. `dp_req`, `dp_we` and `dp_addr` stay stable until `dp_ready` is high.
- R7: When control bit 0 is set, the source address rises by one data word (4 bytes) after each load. When control bit 14 is set, the destination address rises by one word after each store. When a bit is clear, that address is unchanged.
- R8: The write barrier (0x13) holds status 5 until no stores are outstanding. When 2^OST_W-1 stores are already outstanding, a further store request is withheld until an acknowledge arrives.
- R9: Send-event (0x34) gives a one-cycle `ev_valid` pulse with `ev_num` equal to bits [7:3] of byte 1. No-op (0x18) only advances `pc`.
- R10: End (0x00) shows status 9 while stores are outstanding, then status 0. `pc` is left at the address of the end instruction.
- R11: An undefined opcode (0x28 and 0x05 included) or a bad move selector sets status 15 and `undef_fault`. `pc` stays at the faulting instruction. This state is kept until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse, acted on only when stopped |
| start_pc | input | PC_W | Program entry address |
| pc | output | PC_W | Current instruction address |
| status | output | 4 | Channel status code |
| undef_fault | output | 1 | Undefined-instruction fault flag |
| pm_rd_en | output | 1 | Program byte read enable |
| pm_addr | output | PC_W | Program byte address |
| pm_rdata | input | 8 | Program byte, valid one cycle after the read |
| dp_req | output | 1 | Data transfer request |
| dp_we | output | 1 | 1 for store, 0 for load |
| dp_addr | output | 32 | Data byte address |
| dp_wdata | output | DW | Store data |
| dp_rdata | input | DW | Load data, taken when `dp_ready` is high |
| dp_ready | input | 1 | Data port accepts the request |
| dp_wack | input | 1 | One store completed |
| ev_valid | output | 1 | Event pulse |
| ev_num | output | 5 | Event number |

## Verification
The bench uses the default PC_W=16, DW=32 and LC_W=8, so a loop count byte of 255 runs the full 256-iteration boundary. It overrides OST_W to 2, so with acknowledges held back the fourth store stalls at the outstanding limit after only three accepted stores, within a short window. The same held acknowledges keep the barrier and completing states up long enough to sample them, and to show that a `start` pulse in those states is ignored.

// File: rtl/dmach_pkg.sv
package dmach_pkg;

  localparam int IMM_W = 32;

  localparam logic [3:0] CS_STOP  = 4'd0;
  localparam logic [3:0] CS_RUN   = 4'd1;
  localparam logic [3:0] CS_BARR  = 4'd5;
  localparam logic [3:0] CS_COMPL = 4'd9;
  localparam logic [3:0] CS_FAULT = 4'd15;

  localparam logic [7:0] OPC_END = 8'h00;
  localparam logic [7:0] OPC_LD  = 8'h04;
  localparam logic [7:0] OPC_ST  = 8'h08;
  localparam logic [7:0] OPC_BAR = 8'h13;
  localparam logic [7:0] OPC_NOP = 8'h18;
  localparam logic [7:0] OPC_SEV = 8'h34;
  localparam logic [7:0] OPC_MOV = 8'hBC;
  localparam logic [7:0] OPC_LPS = 8'h20;
  localparam logic [7:0] OPC_LPE = 8'h38;

  localparam int SRC_INC_BIT = 0;
  localparam int DST_INC_BIT = 14;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_CAPT, ST_EXEC, ST_XFER, ST_BARR, ST_DRAIN, ST_FAULT
  } state_e;

  typedef enum logic [3:0] {
    OP_END, OP_LD, OP_ST, OP_BAR, OP_NOP, OP_SEV, OP_MOV, OP_LPS, OP_LPE, OP_BAD
  } op_e;

  function automatic logic [3:0] status_of(state_e s);
    case (s)
      ST_IDLE:  return CS_STOP;
      ST_BARR:  return CS_BARR;
      ST_DRAIN: return CS_COMPL;
      ST_FAULT: return CS_FAULT;
      default:  return CS_RUN;
    endcase
  endfunction

endpackage

// File: rtl/dmach_decode.sv
module dmach_decode
  import dmach_pkg::*;
(
  input  logic [7:0] opc,
  output op_e        kind,
  output logic [2:0] len,
  output logic       csel
);
  always_comb begin
    kind = OP_BAD;
    len  = 3'd1;
    csel = 1'b0;
    if (opc == OPC_END) begin
      kind = OP_END;
    end else if (opc == OPC_LD) begin
      kind = OP_LD;
    end else if (opc == OPC_ST) begin
      kind = OP_ST;
    end else if (opc == OPC_BAR) begin
      kind = OP_BAR;
    end else if (opc == OPC_NOP) begin
      kind = OP_NOP;
    end else if (opc == OPC_SEV) begin
      kind = OP_SEV;
      len  = 3'd2;
    end else if (opc == OPC_MOV) begin
      kind = OP_MOV;
      len  = 3'd6;
    end else if ((opc & 8'hFD) == OPC_LPS) begin
      kind = OP_LPS;
      len  = 3'd2;
      csel = opc[1];
    end else if ((opc & 8'hFB) == OPC_LPE) begin
      kind = OP_LPE;
      len  = 3'd2;
      csel = opc[2];
    end
  end
endmodule

// File: rtl/dmach_loopctr.sv
module dmach_loopctr #(
  parameter int CNT_W = 8,
  parameter int NUM   = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [$clog2(NUM)-1:0] sel,
  input  logic                   load,
  input  logic [CNT_W-1:0]       load_val,
  input  logic                   step,
  output logic                   sel_zero
);
  logic [CNT_W-1:0] cnt_q [NUM];

  for (genvar g = 0; g < NUM; g++) begin : g_ctr
    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q[g] <= '0;
      end else if (sel == g) begin
        if (load)      cnt_q[g] <= load_val;
        else if (step) cnt_q[g] <= cnt_q[g] - 1'b1;
      end
    end
  end

  assign sel_zero = (cnt_q[sel] == '0);
endmodule

// File: rtl/dmach_wrtrack.sv
module dmach_wrtrack #(
  parameter int OST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             issue,
  input  logic             ack,
  output logic [OST_W-1:0] count,
  output logic             none,
  output logic             full
);
  localparam logic [OST_W-1:0] MAXC = {OST_W{1'b1}};

  logic [OST_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (issue && !(ack && cnt_q != '0)) begin
      cnt_q <= cnt_q + 1'b1;
    end else if (!issue && ack && cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  assign count = cnt_q;
  assign none  = (cnt_q == '0);
  assign full  = (cnt_q == MAXC);
endmodule

// File: rtl/dmach_exec.sv
module dmach_exec
  import dmach_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DW    = 32,
  parameter int LC_W  = 8,
  parameter int OST_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [PC_W-1:0]  start_pc,
  output logic [PC_W-1:0]  pc,
  output logic [3:0]       status,
  output logic             undef_fault,
  output logic             pm_rd_en,
  output logic [PC_W-1:0]  pm_addr,
  input  logic [7:0]       pm_rdata,
  output logic             dp_req,
  output logic             dp_we,
  output logic [IMM_W-1:0] dp_addr,
  output logic [DW-1:0]    dp_wdata,
  input  logic [DW-1:0]    dp_rdata,
  input  logic             dp_ready,
  input  logic             dp_wack,
  output logic             ev_valid,
  output logic [4:0]       ev_num
);
  localparam int                WBYTES = DW / 8;
  localparam logic [IMM_W-1:0]  ASTEP  = IMM_W'(WBYTES);
  localparam int                MAXLEN = 6;

  state_e           state_q, state_d;
  logic [PC_W-1:0]  pc_q, pc_d;
  logic [2:0]       idx_q, idx_d;
  logic [7:0]       ibuf_q [MAXLEN];
  logic [IMM_W-1:0] src_q, src_d, dst_q, dst_d;
  logic             sinc_q, sinc_d, dinc_q, dinc_d;
  logic [DW-1:0]    hold_q, hold_d;
  logic             fault_q, fault_d;
  logic             ev_q, ev_d;
  logic [4:0]       evn_q, evn_d;
  logic [3:0]       status_q;
  logic             cap_en, lc_load, lc_step, st_acc;

  logic [7:0]       dec_in;
  op_e              dec_kind;
  logic [2:0]       dec_len;
  logic             dec_sel;
  logic             lc_zero;
  logic [OST_W-1:0] ost_cnt;
  logic             ost_none, ost_full;

  logic [7:0]       arg;
  logic [IMM_W-1:0] imm;

  assign dec_in = (state_q == ST_CAPT && idx_q == 3'd0) ? pm_rdata : ibuf_q[0];
  assign arg    = ibuf_q[1];
  assign imm    = {ibuf_q[5], ibuf_q[4], ibuf_q[3], ibuf_q[2]};

  dmach_decode u_dec (
    .opc  (dec_in),
    .kind (dec_kind),
    .len  (dec_len),
    .csel (dec_sel)
  );

  dmach_loopctr #(.CNT_W(LC_W), .NUM(2)) u_lc (
    .clk      (clk),
    .rst      (rst),
    .sel      (dec_sel),
    .load     (lc_load),
    .load_val (arg[LC_W-1:0]),
    .step     (lc_step),
    .sel_zero (lc_zero)
  );

  dmach_wrtrack #(.OST_W(OST_W)) u_wr (
    .clk   (clk),
    .rst   (rst),
    .issue (st_acc),
    .ack   (dp_wack),
    .count (ost_cnt),
    .none  (ost_none),
    .full  (ost_full)
  );

  // Data port, driven from the transfer state
  assign dp_we    = (dec_kind == OP_ST);
  assign dp_req   = (state_q == ST_XFER) && !(dp_we && ost_full);
  assign dp_addr  = dp_we ? dst_q : src_q;
  assign dp_wdata = hold_q;

  assign pm_rd_en = (state_q == ST_FETCH);
  assign pm_addr  = pc_q + PC_W'(idx_q);

  always_comb begin
    state_d = state_q;
    pc_d    = pc_q;
    idx_d   = idx_q;
    src_d   = src_q;
    dst_d   = dst_q;
    sinc_d  = sinc_q;
    dinc_d  = dinc_q;
    hold_d  = hold_q;
    fault_d = fault_q;
    ev_d    = 1'b0;
    evn_d   = evn_q;
    cap_en  = 1'b0;
    lc_load = 1'b0;
    lc_step = 1'b0;
    st_acc  = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start) begin
          pc_d    = start_pc;
          idx_d   = '0;
          state_d = ST_FETCH;
        end
      end
      ST_FETCH: state_d = ST_CAPT;
      ST_CAPT: begin
        cap_en = 1'b1;
        if (idx_q + 3'd1 >= dec_len) begin
          idx_d   = '0;
          state_d = ST_EXEC;
        end else begin
          idx_d   = idx_q + 3'd1;
          state_d = ST_FETCH;
        end
      end
      ST_EXEC: begin
        case (dec_kind)
          OP_END: state_d = ost_none ? ST_IDLE : ST_DRAIN;
          OP_LD, OP_ST: state_d = ST_XFER;
          OP_BAR: begin
            if (ost_none) begin
              pc_d    = pc_q + 1'b1;
              state_d = ST_FETCH;
            end else begin
              state_d = ST_BARR;
            end
          end
          OP_NOP: begin
            pc_d    = pc_q + 1'b1;
            state_d = ST_FETCH;
          end
          OP_SEV: begin
            ev_d    = 1'b1;
            evn_d   = arg[7:3];
            pc_d    = pc_q + PC_W'(2);
            state_d = ST_FETCH;
          end
          OP_MOV: begin
            pc_d    = pc_q + PC_W'(6);
            state_d = ST_FETCH;
            if (arg == 8'd0) begin
              src_d = imm;
            end else if (arg == 8'd1) begin
              sinc_d = imm[SRC_INC_BIT];
              dinc_d = imm[DST_INC_BIT];
            end else if (arg == 8'd2) begin
              dst_d = imm;
            end else begin
              pc_d    = pc_q;
              fault_d = 1'b1;
              state_d = ST_FAULT;
            end
          end
          OP_LPS: begin
            lc_load = 1'b1;
            pc_d    = pc_q + PC_W'(2);
            state_d = ST_FETCH;
          end
          OP_LPE: begin
            if (!lc_zero) begin
              lc_step = 1'b1;
              pc_d    = pc_q - PC_W'(arg);
            end else begin
              pc_d = pc_q + PC_W'(2);
            end
            state_d = ST_FETCH;
          end
          default: begin
            fault_d = 1'b1;
            state_d = ST_FAULT;
          end
        endcase
      end
      ST_XFER: begin
        if (dp_req && dp_ready) begin
          if (dp_we) begin
            st_acc = 1'b1;
            if (dinc_q) dst_d = dst_q + ASTEP;
          end else begin
            hold_d = dp_rdata;
            if (sinc_q) src_d = src_q + ASTEP;
          end
          pc_d    = pc_q + 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_BARR: begin
        if (ost_none) begin
          pc_d    = pc_q + 1'b1;
          state_d = ST_FETCH;
        end
      end
      ST_DRAIN: if (ost_none) state_d = ST_IDLE;
      default: ;
    endcase
  end

  // Instruction bytes: plain storage, no reset needed
  always_ff @(posedge clk) begin
    if (cap_en) ibuf_q[idx_q] <= pm_rdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= ST_IDLE;
      pc_q     <= '0;
      idx_q    <= '0;
      src_q    <= '0;
      dst_q    <= '0;
      sinc_q   <= 1'b0;
      dinc_q   <= 1'b0;
      hold_q   <= '0;
      fault_q  <= 1'b0;
      ev_q     <= 1'b0;
      evn_q    <= '0;
      status_q <= CS_STOP;
    end else begin
      state_q  <= state_d;
      pc_q     <= pc_d;
      idx_q    <= idx_d;
      src_q    <= src_d;
      dst_q    <= dst_d;
      sinc_q   <= sinc_d;
      dinc_q   <= dinc_d;
      hold_q   <= hold_d;
      fault_q  <= fault_d;
      ev_q     <= ev_d;
      evn_q    <= evn_d;
      status_q <= status_of(state_d);
    end
  end

  assign pc          = pc_q;
  assign status      = status_q;
  assign undef_fault = fault_q;
  assign ev_valid    = ev_q;
  assign ev_num      = evn_q;
endmodule

// File: rtl/dmach_exec_chk.sv
module dmach_exec_chk #(
  parameter int PC_W  = 16,
  parameter int OST_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic [PC_W-1:0]  pc,
  input logic [3:0]       status,
  input logic             undef_fault,
  input logic             pm_rd_en,
  input logic             dp_req,
  input logic             dp_we,
  input logic             dp_ready,
  input logic [31:0]      dp_addr,
  input logic             ev_valid,
  input logic [OST_W-1:0] ost_cnt
);
  AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (status == 4'd0 && !undef_fault && !dp_req)); // R1
  AST_STATUS_LEGAL: assert property (@(posedge clk) disable iff (rst)
    status inside {4'd0, 4'd1, 4'd5, 4'd9, 4'd15}); // R2
  AST_FETCH_RUNNING: assert property (@(posedge clk) disable iff (rst)
    pm_rd_en |-> status == 4'd1); // R3
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (dp_req && !dp_ready) |=> (dp_req && $stable(dp_we) && $stable(dp_addr))); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (ost_cnt == {OST_W{1'b1}}) |-> !(dp_req && dp_we)); // R8
  AST_EV_PULSE: assert property (@(posedge clk) disable iff (rst)
    ev_valid |=> !ev_valid); // R9
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (rst)
    (status == 4'd0) |-> (!dp_req && !pm_rd_en)); // R10
  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst)
    (status == 4'd15) |=> (status == 4'd15 && $stable(pc) && undef_fault)); // R11
  AST_FAULT_FLAG: assert property (@(posedge clk) disable iff (rst)
    undef_fault |-> status == 4'd15); // R11
endmodule

bind dmach_exec dmach_exec_chk #(.PC_W(PC_W), .OST_W(OST_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .pc          (pc),
  .status      (status),
  .undef_fault (undef_fault),
  .pm_rd_en    (pm_rd_en),
  .dp_req      (dp_req),
  .dp_we       (dp_we),
  .dp_ready    (dp_ready),
  .dp_addr     (dp_addr),
  .ev_valid    (ev_valid),
  .ost_cnt     (ost_cnt)
);

// File: tb/dmach_exec_tb.sv
`timescale 1ns/1ps
module dmach_exec_tb;
  localparam int PC_W  = 16;
  localparam int DW    = 32;
  localparam int OST_W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic            start = 1'b0;
  logic [PC_W-1:0] start_pc = '0;
  logic [PC_W-1:0] pc;
  logic [3:0]      status;
  logic            undef_fault, pm_rd_en, dp_req, dp_we, dp_ready, dp_wack;
  logic [PC_W-1:0] pm_addr;
  logic [7:0]      pm_rdata;
  logic [31:0]     dp_addr;
  logic [DW-1:0]   dp_wdata, dp_rdata;
  logic            ev_valid;
  logic [4:0]      ev_num;

  dmach_exec #(.PC_W(PC_W), .DW(DW), .LC_W(8), .OST_W(OST_W)) u_dut (
    .clk(clk), .rst(rst), .start(start), .start_pc(start_pc), .pc(pc),
    .status(status), .undef_fault(undef_fault), .pm_rd_en(pm_rd_en),
    .pm_addr(pm_addr), .pm_rdata(pm_rdata), .dp_req(dp_req), .dp_we(dp_we),
    .dp_addr(dp_addr), .dp_wdata(dp_wdata), .dp_rdata(dp_rdata),
    .dp_ready(dp_ready), .dp_wack(dp_wack), .ev_valid(ev_valid), .ev_num(ev_num)
  );

  // Memory models
  logic [7:0]  pmem [256];
  logic [31:0] dmem [64];
  logic [31:0] emem [64];
  logic        rdy_q = 1'b0;
  logic        wack_q = 1'b0;
  logic        ack_hold = 1'b0;
  int          pend = 0;
  int          stores = 0;
  int          ev_cnt = 0;
  int          ev_last = 0;
  int          n_chk = 0;
  int          n_bad = 0;
  int          cyc = 0;

  always_ff @(posedge clk) if (pm_rd_en) pm_rdata <= pmem[pm_addr[7:0]];
  assign dp_rdata = dmem[dp_addr[7:2]];
  assign dp_ready = rdy_q;
  assign dp_wack  = wack_q;

  always @(posedge clk) begin
    int acc;
    cyc <= cyc + 1;
    rdy_q <= ($urandom % 4) != 0;
    acc = (dp_req && dp_ready && dp_we) ? 1 : 0;
    if (acc != 0) begin
      dmem[dp_addr[7:2]] <= dp_wdata;
      stores <= stores + 1;
    end
    wack_q <= !ack_hold && (pend + acc - (wack_q ? 1 : 0)) > 0 && ($urandom % 2 == 0);
    pend <= pend + acc - (wack_q ? 1 : 0);
    if (ev_valid) begin
      ev_cnt  <= ev_cnt + 1;
      ev_last <= ev_num;
    end
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // Program builder
  int wp;
  task automatic put(input int b);
    pmem[wp[7:0]] = b[7:0];
    wp++;
  endtask
  task automatic e_mov(input int sel, input int val);
    put('hBC); put(sel);
    put(val & 'hFF); put((val >> 8) & 'hFF); put((val >> 16) & 'hFF); put((val >> 24) & 'hFF);
  endtask
  task automatic e_lp(input int c, input int n1);
    put('h20 | (c << 1)); put(n1);
  endtask
  task automatic e_lpend(input int c, input int jmp);
    put('h38 | (c << 2)); put(jmp);
  endtask
  task automatic e_sev(input int e);
    put('h34); put(e << 3);
  endtask

  task automatic kick(input int addr);
    @(negedge clk);
    start_pc = addr[PC_W-1:0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_stop(input string req);
    int t;
    t = 0;
    while (status != 4'd0 && t < 20000) begin
      @(negedge clk);
      t++;
    end
    if (t >= 20000) chk(1'b0, req, status, 0);
  endtask

  function automatic int ctl_word(input bit si, input bit di);
    return (si ? 1 : 0) | (di ? 'h4000 : 0);
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin : watchdog
    wait (cyc > 150000);
    chk(1'b0, "watchdog", cyc, 150000);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    int base, n, sidx, didx, e, endp, s0, c, bad;
    bit si, di, nop;
    void'($urandom(32'd20240611));
    for (int i = 0; i < 256; i++) pmem[i] = 8'h00;
    for (int i = 0; i < 64; i++) dmem[i] = $urandom;

    do_reset();
    // R1: reset state
    chk(status == 4'd0, "R1 status", status, 0);
    chk(pc == '0, "R1 pc", pc, 0);
    chk(!undef_fault && !dp_req && !pm_rd_en, "R1 idle outputs",
        {undef_fault, dp_req, pm_rd_en}, 0);

    // Random copy loops: R2..R7, R9, R10
    for (int it = 0; it < 12; it++) begin
      base = 8 * ($urandom % 16);
      n    = 1 + ($urandom % 8);
      sidx = $urandom % 16;
      didx = 32 + ($urandom % 16);
      si   = $urandom % 2;
      di   = $urandom % 2;
      nop  = $urandom % 2;
      c    = $urandom % 2;
      e    = $urandom % 32;
      wp = base;
      e_mov(0, sidx * 4);
      e_mov(2, didx * 4);
      e_mov(1, ctl_word(si, di));
      e_lp(c, n - 1);
      put('h04);
      if (nop) put('h18);
      put('h08);
      e_lpend(c, nop ? 3 : 2);
      put('h13);
      e_sev(e);
      endp = wp;
      put('h00);
      for (int k = 0; k < 64; k++) emem[k] = dmem[k];
      for (int k = 0; k < n; k++) emem[didx + (di ? k : 0)] = emem[sidx + (si ? k : 0)];
      s0 = ev_cnt;
      kick(base);
      chk(status == 4'd1, "R2 executing after start", status, 1);
      wait_stop("R10 copy did not stop");
      repeat (2) @(negedge clk);
      bad = 0;
      for (int k = 0; k < 64; k++) if (dmem[k] !== emem[k]) bad++;
      chk(bad == 0, "R6 R7 copied words", bad, 0);
      chk(pc == endp[PC_W-1:0], "R10 pc at end", pc, endp);
      chk(ev_cnt == s0 + 1 && ev_last == e, "R9 event", ev_last, e);
    end

    // R5: nested loops, 3 x 4 = 12 stores
    wp = 0;
    e_mov(2, 200);
    e_mov(1, 0);
    e_lp(0, 2);
    e_lp(1, 3);
    put('h04); put('h08);
    e_lpend(1, 2);
    e_lpend(0, 6);
    put('h00);
    s0 = stores;
    kick(0);
    wait_stop("R5 nested hang");
    chk(stores - s0 == 12, "R5 nested store count", stores - s0, 12);

    // R5: 256-iteration boundary
    wp = 0;
    e_lp(1, 255);
    put('h08);
    e_lpend(1, 1);
    put('h00);
    s0 = stores;
    kick(0);
    wait_stop("R5 long hang");
    chk(stores - s0 == 256, "R5 256 iterations", stores - s0, 256);

    // R8: outstanding limit stall
    repeat (20) @(negedge clk);
    ack_hold = 1'b1;
    wp = 0;
    e_mov(2, 160);
    e_mov(1, ctl_word(0, 1));
    e_lp(0, 4);
    put('h08);
    e_lpend(0, 1);
    put('h00);
    s0 = stores;
    kick(0);
    repeat (120) @(negedge clk);
    chk(stores - s0 == 3, "R8 stores at limit", stores - s0, 3);
    chk(status == 4'd1 && !dp_req, "R8 store withheld", {status, dp_req}, 4'd1 << 1);
    ack_hold = 1'b0;
    wait_stop("R8 stall hang");
    chk(stores - s0 == 5, "R8 stores after release", stores - s0, 5);

    // R8: write barrier
    repeat (20) @(negedge clk);
    ack_hold = 1'b1;
    wp = 0;
    e_mov(2, 240);
    put('h08);
    put('h13);
    e_sev(7);
    put('h00);
    s0 = ev_cnt;
    kick(0);
    repeat (60) @(negedge clk);
    chk(status == 4'd5, "R8 barrier status", status, 5);
    chk(ev_cnt == s0, "R8 event held by barrier", ev_cnt, s0);
    ack_hold = 1'b0;
    wait_stop("R8 barrier hang");
    chk(ev_cnt == s0 + 1 && ev_last == 7, "R9 event after barrier", ev_last, 7);

    // R10 completing, R2 start ignored
    repeat (20) @(negedge clk);
    ack_hold = 1'b1;
    wp = 0;
    e_mov(2, 244);
    put('h08);
    put('h00);
    kick(0);
    repeat (60) @(negedge clk);
    chk(status == 4'd9, "R10 completing status", status, 9);
    kick(100);
    chk(pc == 16'd7 && status == 4'd9, "R2 start ignored while busy", pc, 7);
    ack_hold = 1'b0;
    wait_stop("R10 drain hang");
    chk(pc == 16'd7, "R10 pc kept at end", pc, 7);

    // R11: undefined opcode 0x05
    wp = 50;
    put('h18);
    put('h05);
    kick(50);
    repeat (20) @(negedge clk);
    chk(status == 4'd15 && undef_fault, "R11 fault on 0x05", status, 15);
    chk(pc == 16'd51, "R11 pc at fault", pc, 51);
    kick(0);
    repeat (5) @(negedge clk);
    chk(status == 4'd15 && pc == 16'd51, "R11 R2 start ignored in fault", pc, 51);
    do_reset();
    chk(status == 4'd0 && !undef_fault && pc == '0, "R1 reset clears fault", status, 0);

    // R4: bad move selector
    wp = 60;
    put('h18);
    e_mov(3, 'h1234);
    kick(60);
    repeat (30) @(negedge clk);
    chk(status == 4'd15 && pc == 16'd61, "R4 bad selector faults", pc, 61);
    do_reset();

    // R11: loop-forever form 0x28 is undefined
    wp = 70;
    put('h28); put(0);
    kick(70);
    repeat (20) @(negedge clk);
    chk(status == 4'd15 && undef_fault && pc == 16'd70, "R11 0x28 faults", pc, 70);
    do_reset();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule